// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block is an 8-bit interrupt control and status register for a small 8-bit processor core. It holds a global enable, a peripheral-group enable and one enable per core source, plus latched flags for three core sources: a timer overflow, an external edge event and a change on the upper four pins of a parallel port. Any flag may be set by its event while its enable is off. Hardware never clears a flag. Software clears a flag by writing it to 0.

The port-change flag is not driven by a strobe. It is raised by a mismatch between the live upper port pins and a snapshot of those pins, and the snapshot is re-taken every time software reads the port address. Until that read happens, the mismatch keeps raising the flag on every cycle, so a clear written by software does not stick. The block combines the flags, the enables and a pending input from a peripheral group into one registered interrupt request to the CPU.

Software reaches the register through a simple address/data bus at two aliased addresses, one in each register bank.

Top module: `irq_ctrl_reg`

## Requirements
- R1: The register bits are, from bit 7 down to bit 0: global enable, peripheral enable, timer enable, external enable, change enable, timer flag, external flag, change flag. A write strobe at address 0x0B or 0x8B loads all eight bits, and enable bits change on no other occasion. A read strobe at either address returns the register on the data output one cycle later. A read strobe at any other address returns 0.
- R2: After reset, all enable bits and all flags read 0 and the interrupt request is 0.
- R3: A one-cycle timer-overflow pulse sets the timer flag (bit 2) at the next clock edge, whatever the state of any enable bit.
- R4: A one-cycle external-event pulse sets the external flag (bit 1) at the next clock edge, whatever the state of any enable bit.
- R5: A set flag stays set until a register write puts a 0 in that bit. If an event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R6: While any of port pins 7 to 4 differs from the snapshot, the change flag (bit 0) is set on every clock edge. Pins 3 to 0 have no effect on the flag.
- R7: A read strobe at the port address (0x06) loads the snapshot from pins 7 to 4. A clear of the change flag written after that read sticks. A clear written before the read is overridden while the pins still differ from the snapshot. The snapshot resets to 0, so the first evaluation after reset sets the change flag if any upper pin is high.
- R8: One cycle after the register state, the interrupt request equals global enable AND (timer enable·timer flag OR external enable·external flag OR change enable·change flag OR peripheral enable·peripheral pending).
- R9: When the global enable is 0, the request is 0 for every source. When the peripheral enable is 0, the peripheral pending input cannot raise the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tmr_ovf | input | 1 | Timer overflow pulse, already synchronous to the core clock |
| ext_evt | input | 1 | External edge pulse, already synchronous to the core clock |
| port_pins | input | 8 | Live parallel port pins |
| periph_pend | input | 1 | OR of the pending requests from the peripheral group |
| irq_req | output | 1 | Registered interrupt request to the CPU |

## Verification
The bench builds the block with its default parameters: an 8-bit address bus and a watch window over the upper four pins of an 8-bit port. With these defaults, both aliased register addresses and the port address can be decoded on the same bus. The bench also drives the lower pins to show that they are ignored. The bench steps the snapshot and clear ordering across single cycles: a clear before the port read, the read itself, and a clear after it. It also lands an event and a clearing write in the same cycle, so the rule that the event wins is exercised directly.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  // Register image, most significant bit first
  typedef struct packed {
    logic ge;   // global enable
    logic pe;   // peripheral group enable
    logic te;   // timer enable
    logic xe;   // external event enable
    logic ce;   // port change enable
    logic tf;   // timer flag
    logic xf;   // external flag
    logic cf;   // port change flag
  } ctrl_t;

  localparam int NUM_SRC = 3;
  localparam int SRC_TMR = 0;
  localparam int SRC_EXT = 1;
  localparam int SRC_CHG = 2;

  // Bit position of the flag for source index i (timer=2, ext=1, change=0)
  function automatic int flag_pos(input int i);
    return NUM_SRC - 1 - i;
  endfunction

endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_val,
  input  logic set_evt,
  output logic flag_q
);

  // Hardware set outranks the software write so no event is lost
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (wr_en)   flag_q <= wr_val;
  end

endmodule

// File: rtl/port_change_detect.sv
module port_change_detect #(
  parameter int PORT_W  = 8,
  parameter int WATCH_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snap_en,
  input  logic [PORT_W-1:0] pins,
  output logic              mismatch
);

  localparam int TOP = PORT_W - 1;

  logic [WATCH_W-1:0] watch;
  logic [WATCH_W-1:0] snap_q;

  assign watch = pins[TOP -: WATCH_W];

  always_ff @(posedge clk) begin
    if (rst)          snap_q <= '0;
    else if (snap_en) snap_q <= watch;
  end

  // Compared against the stored snapshot, so a read in the same cycle
  // still reports the difference it is about to absorb
  assign mismatch = |(watch ^ snap_q);

endmodule

// File: rtl/irq_req_combine.sv
module irq_req_combine
  import irq_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl,
  input  logic  periph_pend,
  output logic  irq_req
);

  logic core_any;
  logic periph_any;
  logic req_d;

  assign core_any   = (ctrl.te & ctrl.tf) | (ctrl.xe & ctrl.xf) | (ctrl.ce & ctrl.cf);
  assign periph_any = ctrl.pe & periph_pend;
  assign req_d      = ctrl.ge & (core_any | periph_any);

  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= req_d;
  end

endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_ctrl_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              PORT_W    = 8,
  parameter int              WATCH_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR_A = 8'h0B,
  parameter logic [ADDR_W-1:0] REG_ADDR_B = 8'h8B,
  parameter logic [ADDR_W-1:0] PORT_ADDR  = 8'h06
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tmr_ovf,
  input  logic              ext_evt,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              periph_pend,
  output logic              irq_req
);

  localparam int EN_W = 8 - NUM_SRC;

  logic              reg_hit;
  logic              reg_wr;
  logic              reg_rd;
  logic              port_rd;
  logic              chg_mismatch;
  logic [EN_W-1:0]   en_q;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] set_v;
  ctrl_t             ctrl_q;

  assign reg_hit = (bus_addr == REG_ADDR_A) || (bus_addr == REG_ADDR_B);
  assign reg_wr  = bus_wr & reg_hit;
  assign reg_rd  = bus_rd & reg_hit;
  assign port_rd = bus_rd & (bus_addr == PORT_ADDR);

  // Enable bits: software only
  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (reg_wr) en_q <= bus_wdata[7 -: EN_W];
  end

  port_change_detect #(
    .PORT_W (PORT_W),
    .WATCH_W(WATCH_W)
  ) u_chg (
    .clk     (clk),
    .rst     (rst),
    .snap_en (port_rd),
    .pins    (port_pins),
    .mismatch(chg_mismatch)
  );

  assign set_v[SRC_TMR] = tmr_ovf;
  assign set_v[SRC_EXT] = ext_evt;
  assign set_v[SRC_CHG] = chg_mismatch;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    localparam int POS = flag_pos(i);
    irq_flag_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (reg_wr),
      .wr_val (bus_wdata[POS]),
      .set_evt(set_v[i]),
      .flag_q (flag_q[i])
    );
  end

  assign ctrl_q = {en_q, flag_q[SRC_TMR], flag_q[SRC_EXT], flag_q[SRC_CHG]};

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (reg_rd) bus_rdata <= ctrl_q;
    else             bus_rdata <= '0;
  end

  irq_req_combine u_comb (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl_q),
    .periph_pend(periph_pend),
    .irq_req    (irq_req)
  );

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic       tmr_ovf,
  input logic       ext_evt,
  input logic       mismatch,
  input logic [7:0] ctrl,
  input logic       irq_req
);

  // R3
  tmr_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf |=> ctrl[2]);

  // R4
  ext_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    ext_evt |=> ctrl[1]);

  // R6
  chg_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> ctrl[0]);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> ((ctrl[2:0] & $past(ctrl[2:0])) == $past(ctrl[2:0])));

  // R1
  en_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> $stable(ctrl[7:3]));

  // R9
  ge_block_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl[7] |=> !irq_req);

  // R8
  tmr_req_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl[7] && ctrl[5] && ctrl[2]) |=> irq_req);

  // R8
  chg_req_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl[7] && ctrl[3] && ctrl[0] && !ctrl[6]) |=> irq_req);

endmodule

bind irq_ctrl_reg irq_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .reg_wr  (reg_wr),
  .tmr_ovf (tmr_ovf),
  .ext_evt (ext_evt),
  .mismatch(chg_mismatch),
  .ctrl    (ctrl_q),
  .irq_req (irq_req)
);

// File: tb/irq_ctrl_reg_bench.sv
module irq_ctrl_reg_bench;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tmr_ovf = 1'b0;
  logic       ext_evt = 1'b0;
  logic [7:0] port_pins = '0;
  logic       periph_pend = 1'b0;
  logic       irq_req;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  logic rd_q = 1'b0;
  item_t exp_q[$];

  always #4 clk = ~clk;

  irq_ctrl_reg u_irq_ctrl_reg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf), .ext_evt(ext_evt),
    .port_pins(port_pins), .periph_pend(periph_pend), .irq_req(irq_req)
  );

  // Monitor: a read strobe captured at a posedge has its data valid at the next negedge
  always @(posedge clk) rd_q <= bus_rd;

  always @(negedge clk) begin
    if (rd_q && !rst) begin
      item_t it;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: read data %02h with no expected item", bus_rdata);
      end else begin
        it = exp_q.pop_front();
        checks++;
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: rdata actual %02h expected %02h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    idle();
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq_req !== e) begin
      errors++;
      $display("FAIL %s: irq_req actual %0b expected %0b", tag, irq_req, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    // R2 reset state
    rd(8'h0B, 8'h00, "R2 reset value");
    chk_irq(1'b0, "R2 reset request");

    // R3 timer flag latches with every enable off
    tmr_ovf = 1'b1; idle(); tmr_ovf = 1'b0;
    rd(8'h0B, 8'h04, "R3 timer flag set, enables off");
    chk_irq(1'b0, "R9 no request with enables off");

    // R5 flag holds, then software clear
    idle(); idle();
    rd(8'h0B, 8'h04, "R5 flag held");
    wr(8'h0B, 8'h00);
    rd(8'h0B, 8'h00, "R5 flag cleared by write");

    // R4 external flag
    ext_evt = 1'b1; idle(); ext_evt = 1'b0;
    rd(8'h8B, 8'h02, "R4 external flag set");

    // R1 alias address write/read, other address reads 0
    wr(8'h8B, 8'hA0);
    rd(8'h0B, 8'hA0, "R1 write at alias, read at primary");
    rd(8'h33, 8'h00, "R1 unmapped address reads 0");

    // R8 timer path raises request
    tmr_ovf = 1'b1; idle(); tmr_ovf = 1'b0;
    idle();
    chk_irq(1'b1, "R8 timer request");
    rd(8'h8B, 8'hA4, "R8 register after timer event");

    // R9 global enable off blocks request
    wr(8'h0B, 8'h24);
    idle();
    chk_irq(1'b0, "R9 global enable off");

    // R9 peripheral path and its gating
    wr(8'h0B, 8'hC0);
    periph_pend = 1'b1;
    idle(); idle();
    chk_irq(1'b1, "R8 peripheral request");
    wr(8'h0B, 8'h80);
    idle();
    chk_irq(1'b0, "R9 peripheral enable off");
    periph_pend = 1'b0;
    wr(8'h0B, 8'h00);

    // R6 upper pin change, R7 clear before port read does not stick
    port_pins = 8'h10;
    idle();
    rd(8'h0B, 8'h01, "R6 change flag on pin 4");
    wr(8'h0B, 8'h00);
    rd(8'h0B, 8'h01, "R7 clear before port read overridden");
    rd(8'h06, 8'h00, "R7 port read returns 0 on this bus");
    wr(8'h0B, 8'h00);
    rd(8'h0B, 8'h00, "R7 clear after port read sticks");

    // R6 lower pins ignored
    port_pins = 8'h1F;
    idle(); idle();
    rd(8'h0B, 8'h00, "R6 lower pins ignored");

    // R5 set wins over same-cycle clear
    bus_addr = 8'h0B; bus_wdata = 8'h00; bus_wr = 1'b1; tmr_ovf = 1'b1;
    idle();
    bus_wr = 1'b0; tmr_ovf = 1'b0;
    rd(8'h0B, 8'h04, "R5 event beats clearing write");

    // R8 change path with change enable
    wr(8'h0B, 8'h88);
    port_pins = 8'h9F;
    idle(); idle();
    chk_irq(1'b1, "R8 change request");
    rd(8'h0B, 8'h89, "R6 change flag set by pin 7");

    idle();
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule